// File: doc/BRIEF.md
# Port Input Debounce Filter

This block cleans up the levels of one eight-pin input port before they reach the input sampling and interrupt detection logic. It sits directly behind the input synchronizer. Each pin can opt in to filtering on its own. All pins that opt in share a single stability time, given as a count of millisecond ticks. A filtered pin passes a new level to its output only once that level has held for the programmed number of ticks. A pin that has not opted in passes its input straight through, one register stage later.

The millisecond strobe arrives as an input pulse one clock wide. The shared count is loaded by a plain write. The per-pin enables are changed by a masked write that touches only the selected bits, so software can change one pin without a read-modify-write.

Top module: `dbc_port_filter`

## Requirements
- R1: While `rst` is high, `filt_out` takes `raw_in` on every clock edge and `cnt_q` and `en_q` become 0. After the first edge with `rst` low, the outputs reflect the first clock of normal operation.
- R2: A cycle with `cnt_wr` high loads `cnt_wr_data` into `cnt_q` at that clock edge. Without `cnt_wr`, `cnt_q` keeps its value.
- R3: A cycle with `en_wr` high updates every bit `i` of `en_q` for which `en_wr_data[8+i]` (the mask half) is 1 to `en_wr_data[i]` (the value half). Bits whose mask bit is 0 keep their value. Without `en_wr`, `en_q` is unchanged.
- R4: A pin whose `en_q` bit is 0 drives `filt_out` with the `raw_in` value sampled at the previous clock edge.
- R5: When `cnt_q` is 0, every pin bypasses the filter as in R4, even if its enable bit is 1.
- R6: For an enabled pin with `cnt_q` = N > 0, whose raw level differs from its output, the output takes the raw level at the edge of the Nth tick. That edge is the Nth edge with `tick` high, counted while the difference holds without a break.
- R7: If the raw level of an enabled pin equals its output at any edge, the pin's tick count restarts from zero. A glitch shorter than N ticks therefore never reaches `filt_out`.
- R8: Clock edges without `tick` neither advance the tick count nor change the output of an enabled pin.
- R9: Each pin keeps its own tick count. Activity on one pin does not shift the timing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Millisecond strobe, one clock wide |
| raw_in | input | 8 | Synchronized pin levels |
| cnt_wr | input | 1 | Load strobe for the shared count |
| cnt_wr_data | input | 8 | New stability count in ticks |
| en_wr | input | 1 | Masked write strobe for the enables |
| en_wr_data | input | 16 | [15:8] bit select mask, [7:0] new enable values |
| filt_out | output | 8 | Filtered pin levels |
| cnt_q | output | 8 | Current shared count |
| en_q | output | 8 | Current per-pin enables |

## Verification
The bench places the deciding tick exactly at the Nth edge. A filter with an off-by-one error would switch one tick early or late, and the mismatch would show on that cycle. The bench sends glitches that end one tick short of the count. A design that failed to restart its count on a match would let those glitches through. The bench also sets a count of zero with the enables still set, which catches a design that then never switches or waits 256 ticks. Masked writes with disjoint masks and a random mix of ticks and pin activity expose a shared or mis-indexed per-pin counter, and any disturbance of bits that were not selected.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int PORT_PINS = 8;
  localparam int COUNT_W   = 8;

  typedef enum logic [2:0] {
    PF_BYPASS,
    PF_MATCH,
    PF_WAIT,
    PF_STEP,
    PF_FLIP
  } pf_action_e;
endpackage

// File: rtl/dbc_cfg_regs.sv
module dbc_cfg_regs #(
  parameter int PINS = 8,
  parameter int CW   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_wr,
  input  logic [CW-1:0]     cnt_wr_data,
  input  logic              en_wr,
  input  logic [2*PINS-1:0] en_wr_data,
  output logic [CW-1:0]     cnt_q,
  output logic [PINS-1:0]   en_q
);
  logic [PINS-1:0] sel_mask;
  logic [PINS-1:0] sel_val;

  assign sel_mask = en_wr_data[2*PINS-1:PINS];
  assign sel_val  = en_wr_data[PINS-1:0];

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_wr) cnt_q <= cnt_wr_data;
  end

  for (genvar g = 0; g < PINS; g++) begin : g_en_bit
    always_ff @(posedge clk) begin
      if (rst) en_q[g] <= 1'b0;
      else if (en_wr && sel_mask[g]) en_q[g] <= sel_val[g];
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cnt_wr |=> cnt_q == $past(cnt_q));

  // R3
  en_unselected_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((en_q ^ $past(en_q)) & ~($past(en_wr) ? $past(sel_mask) : '0)) == '0);
endmodule

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter
  import dbc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          raw,
  input  logic          enable,
  input  logic [CW-1:0] limit,
  output logic          out
);
  logic [CW-1:0] ctr;
  logic [CW:0]   ctr_inc;
  pf_action_e    act;

  assign ctr_inc = {1'b0, ctr} + 1'b1;

  always_comb begin
    if (!enable || limit == '0)           act = PF_BYPASS;
    else if (raw == out)                  act = PF_MATCH;
    else if (!tick)                       act = PF_WAIT;
    else if (ctr_inc >= {1'b0, limit})    act = PF_FLIP;
    else                                  act = PF_STEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out <= raw;
      ctr <= '0;
    end else begin
      case (act)
        PF_BYPASS: begin out <= raw; ctr <= '0; end
        PF_MATCH:  ctr <= '0;
        PF_STEP:   ctr <= ctr_inc[CW-1:0];
        PF_FLIP:   begin out <= raw; ctr <= '0; end
        default:   ;
      endcase
    end
  end

  // R4 R5
  bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (!enable || limit == '0) |=> out == $past(raw));

  // R8
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && limit != '0 && !tick) |=> out == $past(out));

  // R7
  restart_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && limit != '0 && raw == out) |=> ctr == '0);
endmodule

// File: rtl/dbc_port_filter.sv
module dbc_port_filter
  import dbc_pkg::*;
#(
  parameter int PINS = PORT_PINS,
  parameter int CW   = COUNT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [PINS-1:0]   raw_in,
  input  logic              cnt_wr,
  input  logic [CW-1:0]     cnt_wr_data,
  input  logic              en_wr,
  input  logic [2*PINS-1:0] en_wr_data,
  output logic [PINS-1:0]   filt_out,
  output logic [CW-1:0]     cnt_q,
  output logic [PINS-1:0]   en_q
);
  dbc_cfg_regs #(.PINS(PINS), .CW(CW)) u_cfg (
    .clk         (clk),
    .rst         (rst),
    .cnt_wr      (cnt_wr),
    .cnt_wr_data (cnt_wr_data),
    .en_wr       (en_wr),
    .en_wr_data  (en_wr_data),
    .cnt_q       (cnt_q),
    .en_q        (en_q)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    dbc_pin_filter #(.CW(CW)) u_pin (
      .clk    (clk),
      .rst    (rst),
      .tick   (tick),
      .raw    (raw_in[p]),
      .enable (en_q[p]),
      .limit  (cnt_q),
      .out    (filt_out[p])
    );
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && en_q == '0 && filt_out == $past(raw_in)));
endmodule

// File: tb/dbc_port_filter_tb.sv
`timescale 1ns/1ps
module dbc_port_filter_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  raw_in = 8'hA5;
  logic        cnt_wr = 1'b0;
  logic [7:0]  cnt_wr_data = '0;
  logic        en_wr = 1'b0;
  logic [15:0] en_wr_data = '0;
  logic [7:0]  filt_out, cnt_q, en_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string tag = "R1";

  logic [7:0] m_out, m_en, m_cnt;
  int         m_ctr [8];

  always #10 clk = ~clk;

  dbc_port_filter u_dut (
    .clk(clk), .rst(rst), .tick(tick), .raw_in(raw_in),
    .cnt_wr(cnt_wr), .cnt_wr_data(cnt_wr_data),
    .en_wr(en_wr), .en_wr_data(en_wr_data),
    .filt_out(filt_out), .cnt_q(cnt_q), .en_q(en_q)
  );

  // reference behaviour derived from R1..R9
  always @(posedge clk) begin
    if (rst) begin
      m_out = raw_in; m_en = '0; m_cnt = '0;
      for (int i = 0; i < 8; i++) m_ctr[i] = 0;
    end else begin
      for (int i = 0; i < 8; i++) begin
        if (!m_en[i] || m_cnt == 0) begin m_out[i] = raw_in[i]; m_ctr[i] = 0; end
        else if (raw_in[i] == m_out[i]) m_ctr[i] = 0;
        else if (tick) begin
          if (m_ctr[i] + 1 >= int'(m_cnt)) begin m_out[i] = raw_in[i]; m_ctr[i] = 0; end
          else m_ctr[i] = m_ctr[i] + 1;
        end
      end
      if (cnt_wr) m_cnt = cnt_wr_data;
      if (en_wr) m_en = (m_en & ~en_wr_data[15:8]) | (en_wr_data[7:0] & en_wr_data[15:8]);
    end
  end

  task automatic chk(input string t, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %06h expected %06h (out,cnt,en)", t, act, exp);
    end
  endtask

  // apply current inputs for one clock, then compare at the following negedge
  task automatic step(input bit tk, input logic [7:0] raw);
    tick = tk; raw_in = raw;
    @(negedge clk);
    chk(tag, {filt_out, cnt_q, en_q}, {m_out, m_cnt, m_en});
    cnt_wr = 1'b0; en_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    cnt_wr = 1'b1; cnt_wr_data = v;
    step(1'b0, raw_in);
  endtask

  task automatic wr_en(input logic [7:0] mask, input logic [7:0] val);
    en_wr = 1'b1; en_wr_data = {mask, val};
    step(1'b0, raw_in);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    tag = "R1";
    raw_in = 8'h3C;
    @(negedge clk);
    chk("R1 reset state", {filt_out, cnt_q, en_q}, {8'h3C, 8'h00, 8'h00});

    tag = "R4";
    step(1'b0, 8'hC3);
    chk("R4 bypass follows", {16'h0, filt_out}, {16'h0, 8'hC3});
    step(1'b1, 8'h0F);

    tag = "R2";
    wr_cnt(8'd3);
    chk("R2 count loaded", {16'h0, cnt_q}, 24'd3);
    step(1'b0, raw_in);
    chk("R2 count held", {16'h0, cnt_q}, 24'd3);

    tag = "R3";
    wr_en(8'h0F, 8'h05);
    chk("R3 masked low", {16'h0, en_q}, {16'h0, 8'h05});
    wr_en(8'hF0, 8'hFA);
    chk("R3 masked high keeps low", {16'h0, en_q}, {16'h0, 8'hF5});
    wr_en(8'h0A, 8'h0F);
    chk("R3 set bits 1 and 3", {16'h0, en_q}, {16'h0, 8'hFF});

    // R6 and R8: three ticks with idle cycles between
    tag = "R6";
    step(1'b0, 8'hF0);
    step(1'b1, 8'hF0);
    step(1'b0, 8'hF0);
    step(1'b1, 8'hF0);
    tag = "R8";
    step(1'b0, 8'hF0);
    step(1'b0, 8'hF0);
    chk("R8 no change before third tick", {16'h0, filt_out}, {16'h0, 8'h0F});
    tag = "R6";
    step(1'b1, 8'hF0);
    chk("R6 switch on third tick", {16'h0, filt_out}, {16'h0, 8'hF0});

    // R7 glitch of two ticks, returns, then two more ticks
    tag = "R7";
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    step(1'b0, 8'hF0);
    step(1'b1, 8'h00);
    step(1'b1, 8'h00);
    chk("R7 glitch filtered", {16'h0, filt_out}, {16'h0, 8'hF0});
    step(1'b1, 8'h00);
    chk("R7 third tick switches", {16'h0, filt_out}, {16'h0, 8'h00});

    // R9: pins with staggered starts
    tag = "R9";
    step(1'b1, 8'h01);
    step(1'b1, 8'h03);
    step(1'b1, 8'h03);
    chk("R9 pin0 only", {16'h0, filt_out}, {16'h0, 8'h01});
    step(1'b1, 8'h03);
    chk("R9 pin1 later", {16'h0, filt_out}, {16'h0, 8'h03});

    // R5: zero count with enables set
    tag = "R5";
    wr_cnt(8'd0);
    step(1'b0, 8'h99);
    chk("R5 zero count bypass", {16'h0, filt_out}, {16'h0, 8'h99});

    // random mix
    tag = "R9 random";
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] flip;
      flip = '0;
      for (int b = 0; b < 8; b++) if ($urandom_range(0, 9) == 0) flip[b] = 1'b1;
      if ($urandom_range(0, 59) == 0) begin
        cnt_wr = 1'b1; cnt_wr_data = 8'($urandom_range(0, 5));
      end
      if ($urandom_range(0, 39) == 0) begin
        en_wr = 1'b1; en_wr_data = 16'($urandom);
      end
      step($urandom_range(0, 3) == 0, raw_in ^ flip);
    end

    done = 1;
    finish_run();
  end
endmodule